// File: doc/BRIEF.md
# Clock Mode Transition Controller

This block holds the operating clock mode of a small microcontroller and decides which mode changes are allowed. A request names a target mode, together with a medium-speed divider code and a PLL multiplier code. The controller checks the request against a fixed graph of legal moves. A legal request starts a switch. An illegal one is dropped, and a sticky error flag records it. The outputs drive the CPU clock source select, the main-clock divider, the PLL multiplier and the four oscillator enables.

When a switch changes the CPU clock source, the controller first turns on the target oscillator. It then holds a busy status until that oscillator reports a stable clock. If the stable signal does not arrive within a programmable number of cycles, the switch is abandoned. Some modes apply extra rules:

- The PLL mode has a single way in and a single way out, through the full-speed mode.
- The two sub-clock modes and the two ring-oscillator modes never reach each other directly.
- Leaving a ring-oscillator mode for the main clock requires the divide-by-8 lock bit to be set.
- Entering the sub-clock low-power mode sets that lock bit and freezes it.

Requests to enter wait or stop are only screened for the current mode.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the mode is medium-speed (code 2), the CPU source is main (code 0), the divide-by-8 lock is 1 (divider log2 = 3), only the main oscillator is enabled (oscEn = 4'b0001), and busy and the error flag are 0.
- R2: Mode codes are: 0 full-speed, 1 PLL, 2 medium-speed, 3 sub-clock, 4 sub-clock low-power, 5 ring, 6 ring low-power; code 7 is rejected. CPU source codes are main 0, sub 1, PLL 2, ring 3. mainDivLog2 is 0 in full-speed mode. In medium-speed mode it is 3 when the lock is 1, else reqDivCode+1 (codes 0..3 select /2, /4, /8, /16). In all other modes it is 0.
- R3: PLL mode (code 1) is accepted only from full-speed mode, and from PLL mode only full-speed mode is accepted. pllMulCode takes the multiplier code of the accepted request (0..3 select x2, x4, x6, x8).
- R4: A wait/stop request made in PLL mode is rejected and sets the error flag. In any other idle mode it gives a one-cycle slowAck pulse in the cycle after the request.
- R5: Direct moves between {3, 4} and {5, 6} are rejected in both directions.
- R6: From modes 5 or 6, full-speed mode is rejected, and medium-speed mode is accepted only while the divide-by-8 lock is 1. The result is medium-speed at /8.
- R7: Mode 4 is accepted only from mode 3. It disables the main oscillator and forces the lock to 1. Lock writes are ignored while in mode 4, and full-speed mode is rejected from it.
- R8: A switch to a different CPU source completes only in a cycle in which that source's oscRdy bit is 1. While it waits, busy is 1 and the target oscillator's oscEn bit is 1. oscRdy and oscEn bits are ordered main 0, sub 1, PLL 2, ring 3.
- R9: Mode requests and wait/stop requests arriving while busy is 1 are ignored.
- R10: If the target source is not ready after timeoutCfg+1 waiting cycles, the switch is abandoned, the mode is unchanged, busy falls and the error flag is set.
- R11: A rejected request leaves the mode, divider and multiplier unchanged. The error flag stays set until an errRd strobe clears it.
- R12: In idle, oscEn bit 0 = modes 0..3, bit 1 = modes 3..4, bit 2 = mode 1, and bit 3 = modes 5..6 or (modes 3..4 with periphRingSel = 1). periphRing follows bit 3's mode condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Mode change request strobe |
| reqMode | input | 3 | Requested mode code |
| reqDivCode | input | 2 | Medium-speed divider code for the request |
| reqMulCode | input | 2 | PLL multiplier code for the request |
| slowReq | input | 1 | Wait/stop entry request strobe |
| div8Wr | input | 1 | Write strobe for the divide-by-8 lock |
| div8Val | input | 1 | Value written to the lock |
| periphRingSel | input | 1 | Selects the ring oscillator as peripheral clock in sub-clock modes |
| errRd | input | 1 | Reads and clears the error flag |
| timeoutCfg | input | TO_W | Stable-wait timeout limit in cycles |
| oscRdy | input | 4 | Oscillator stable flags (main, sub, PLL, ring) |
| curMode | output | 3 | Current mode code |
| cpuSrc | output | 2 | CPU clock source select |
| mainDivLog2 | output | 3 | Main clock divider as log2 |
| pllMulCode | output | 2 | PLL multiplier code |
| oscEn | output | 4 | Oscillator enables (main, sub, PLL, ring) |
| periphRing | output | 1 | Peripheral clock taken from ring oscillator |
| div8 | output | 1 | Divide-by-8 lock bit |
| busy | output | 1 | Switch waiting for a stable source |
| errFlag | output | 1 | Sticky error flag |
| slowAck | output | 1 | Wait/stop request accepted pulse |

## Verification
The bench builds the block with TO_W = 6 and drives timeoutCfg = 5. At that setting an abandoned switch finishes within about seven cycles, so the abort path can be reached and its exact cycle boundary checked. With this width the counter also exercises its compare against a value far below its wrap point. The random phase holds every oscRdy bit high, so each legal request completes in two cycles. That lets a long run of random mode, divider, lock and peripheral-select traffic walk the whole legality graph. The directed phase covers the stable-wait, the ignored requests and the timeout.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  localparam logic [2:0] MD_FAST   = 3'd0;
  localparam logic [2:0] MD_PLL    = 3'd1;
  localparam logic [2:0] MD_MID    = 3'd2;
  localparam logic [2:0] MD_SUB    = 3'd3;
  localparam logic [2:0] MD_SUBLP  = 3'd4;
  localparam logic [2:0] MD_RING   = 3'd5;
  localparam logic [2:0] MD_RINGLP = 3'd6;

  localparam int NUM_OSC = 4;

  localparam logic [1:0] SRC_MAIN = 2'd0;
  localparam logic [1:0] SRC_SUB  = 2'd1;
  localparam logic [1:0] SRC_PLL  = 2'd2;
  localparam logic [1:0] SRC_RING = 2'd3;

  typedef struct packed {
    logic capture;   // latch a legal request as the pending target
    logic commit;    // pending target becomes the live mode
    logic raiseErr;  // rejection or timeout
    logic slowOk;    // wait/stop request accepted
  } strobe_t;

  function automatic logic isSubFam(input logic [2:0] m);
    return (m == MD_SUB) || (m == MD_SUBLP);
  endfunction

  function automatic logic isRingFam(input logic [2:0] m);
    return (m == MD_RING) || (m == MD_RINGLP);
  endfunction

  function automatic logic [1:0] srcOf(input logic [2:0] m);
    logic [1:0] s;
    if (m == MD_PLL)        s = SRC_PLL;
    else if (isSubFam(m))   s = SRC_SUB;
    else if (isRingFam(m))  s = SRC_RING;
    else                    s = SRC_MAIN;
    return s;
  endfunction

  function automatic logic moveAllowed(input logic [2:0] cur, input logic [2:0] tgt,
                                       input logic lock8);
    logic ok;
    ok = 1'b1;
    if (tgt > MD_RINGLP)                              ok = 1'b0;
    else if (tgt == cur)                              ok = 1'b1;
    else if (tgt == MD_PLL)                           ok = (cur == MD_FAST);
    else if (cur == MD_PLL)                           ok = (tgt == MD_FAST);
    else if (tgt == MD_SUBLP)                         ok = (cur == MD_SUB);
    else if (tgt == MD_RINGLP)                        ok = (cur == MD_RING);
    else if (isSubFam(cur) && isRingFam(tgt))         ok = 1'b0;
    else if (isRingFam(cur) && isSubFam(tgt))         ok = 1'b0;
    else if (isRingFam(cur) && tgt == MD_FAST)        ok = 1'b0;
    else if (isRingFam(cur) && tgt == MD_MID)         ok = lock8;
    else if (cur == MD_SUBLP && tgt == MD_FAST)       ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/clk_mode_ctrl_fsm.sv
module clk_mode_ctrl_fsm
  import clk_mode_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [2:0]           reqMode,
  input  logic                 slowReq,
  input  logic [2:0]           curMode,
  input  logic [2:0]           tgtMode,
  input  logic                 lock8,
  input  logic [NUM_OSC-1:0]   oscRdy,
  input  logic [TO_W-1:0]      timeoutCfg,
  output strobe_t              stb,
  output logic                 busy
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e          stateQ, stateD;
  logic [TO_W-1:0] waitCnt;
  logic [1:0]      tgtSrc;
  logic            srcOk;

  assign tgtSrc = srcOf(tgtMode);
  assign srcOk  = oscRdy[tgtSrc] || (tgtSrc == srcOf(curMode));

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (moveAllowed(curMode, reqMode, lock8)) begin
            stb.capture = 1'b1;
            stateD      = ST_WAIT;
          end else begin
            stb.raiseErr = 1'b1;
          end
        end else if (slowReq) begin
          if (curMode == MD_PLL) stb.raiseErr = 1'b1;
          else                   stb.slowOk   = 1'b1;
        end
      end
      ST_WAIT: begin
        if (srcOk) begin
          stb.commit = 1'b1;
          stateD     = ST_IDLE;
        end else if (waitCnt == timeoutCfg) begin
          stb.raiseErr = 1'b1;
          stateD       = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_WAIT && stateD == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      else                                        waitCnt <= '0;
    end
  end

  assign busy = (stateQ == ST_WAIT);

endmodule

// File: rtl/clk_mode_ctrl_dp.sv
module clk_mode_ctrl_dp
  import clk_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               busy,
  input  logic [2:0]         reqMode,
  input  logic [1:0]         reqDivCode,
  input  logic [1:0]         reqMulCode,
  input  logic               div8Wr,
  input  logic               div8Val,
  input  logic               periphRingSel,
  input  logic               errRd,
  output logic [2:0]         curMode,
  output logic [2:0]         tgtMode,
  output logic [1:0]         cpuSrc,
  output logic [2:0]         mainDivLog2,
  output logic [1:0]         pllMulCode,
  output logic [NUM_OSC-1:0] oscEn,
  output logic               periphRing,
  output logic               div8,
  output logic               errFlag,
  output logic               slowAck
);

  logic [2:0] modeQ, tgtQ;
  logic [1:0] divQ, divTgt, mulQ, mulTgt;
  logic       lockQ, errQ, ackQ;
  logic [NUM_OSC-1:0] baseEn;
  logic [1:0] pendSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MD_MID;
      tgtQ   <= MD_MID;
      divQ   <= '0;
      divTgt <= '0;
      mulQ   <= '0;
      mulTgt <= '0;
      lockQ  <= 1'b1;
      errQ   <= 1'b0;
      ackQ   <= 1'b0;
    end else begin
      if (stb.capture) begin
        tgtQ   <= reqMode;
        divTgt <= reqDivCode;
        mulTgt <= reqMulCode;
      end
      if (stb.commit) begin
        modeQ <= tgtQ;
        divQ  <= divTgt;
        mulQ  <= mulTgt;
      end
      if (stb.commit && tgtQ == MD_SUBLP)   lockQ <= 1'b1;
      else if (div8Wr && modeQ != MD_SUBLP) lockQ <= div8Val;
      if (stb.raiseErr) errQ <= 1'b1;
      else if (errRd)   errQ <= 1'b0;
      ackQ <= stb.slowOk;
    end
  end

  // per-mode enables of the live mode
  assign baseEn[SRC_MAIN] = (modeQ == MD_FAST) || (modeQ == MD_PLL) ||
                            (modeQ == MD_MID)  || (modeQ == MD_SUB);
  assign baseEn[SRC_SUB]  = isSubFam(modeQ);
  assign baseEn[SRC_PLL]  = (modeQ == MD_PLL);
  assign baseEn[SRC_RING] = isRingFam(modeQ) || (isSubFam(modeQ) && periphRingSel);

  assign pendSrc = srcOf(tgtQ);

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_oscEn
    assign oscEn[g] = baseEn[g] || (busy && pendSrc == g[1:0]);
  end

  always_comb begin
    mainDivLog2 = 3'd0;
    if (modeQ == MD_MID) mainDivLog2 = lockQ ? 3'd3 : ({1'b0, divQ} + 3'd1);
  end

  assign curMode    = modeQ;
  assign tgtMode    = tgtQ;
  assign cpuSrc     = srcOf(modeQ);
  assign pllMulCode = mulQ;
  assign periphRing = baseEn[SRC_RING];
  assign div8       = lockQ;
  assign errFlag    = errQ;
  assign slowAck    = ackQ;

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      reqMode,
  input  logic [1:0]      reqDivCode,
  input  logic [1:0]      reqMulCode,
  input  logic            slowReq,
  input  logic            div8Wr,
  input  logic            div8Val,
  input  logic            periphRingSel,
  input  logic            errRd,
  input  logic [TO_W-1:0] timeoutCfg,
  input  logic [3:0]      oscRdy,
  output logic [2:0]      curMode,
  output logic [1:0]      cpuSrc,
  output logic [2:0]      mainDivLog2,
  output logic [1:0]      pllMulCode,
  output logic [3:0]      oscEn,
  output logic            periphRing,
  output logic            div8,
  output logic            busy,
  output logic            errFlag,
  output logic            slowAck
);

  strobe_t    stb;
  logic [2:0] tgtMode;

  clk_mode_ctrl_fsm #(.TO_W(TO_W)) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqMode    (reqMode),
    .slowReq    (slowReq),
    .curMode    (curMode),
    .tgtMode    (tgtMode),
    .lock8      (div8),
    .oscRdy     (oscRdy),
    .timeoutCfg (timeoutCfg),
    .stb        (stb),
    .busy       (busy)
  );

  clk_mode_ctrl_dp u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .busy          (busy),
    .reqMode       (reqMode),
    .reqDivCode    (reqDivCode),
    .reqMulCode    (reqMulCode),
    .div8Wr        (div8Wr),
    .div8Val       (div8Val),
    .periphRingSel (periphRingSel),
    .errRd         (errRd),
    .curMode       (curMode),
    .tgtMode       (tgtMode),
    .cpuSrc        (cpuSrc),
    .mainDivLog2   (mainDivLog2),
    .pllMulCode    (pllMulCode),
    .oscEn         (oscEn),
    .periphRing    (periphRing),
    .div8          (div8),
    .errFlag       (errFlag),
    .slowAck       (slowAck)
  );

endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk
  import clk_mode_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] curMode,
  input logic [3:0] oscRdy,
  input logic [3:0] oscEn,
  input logic       div8,
  input logic       busy,
  input logic       errFlag,
  input logic       errRd,
  input logic       slowAck
);

  logic [2:0] prevMode;
  logic [3:0] prevRdy;
  logic       prevBusy, prevErr, prevErrRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMode  <= MD_MID;
      prevRdy   <= '0;
      prevBusy  <= 1'b0;
      prevErr   <= 1'b0;
      prevErrRd <= 1'b0;
    end else begin
      prevMode  <= curMode;
      prevRdy   <= oscRdy;
      prevBusy  <= busy;
      prevErr   <= errFlag;
      prevErrRd <= errRd;
    end
  end

  // R3
  pll_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MD_PLL && prevMode != MD_PLL) |-> prevMode == MD_FAST);

  // R3
  pll_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevMode == MD_PLL && curMode != MD_PLL) |-> curMode == MD_FAST);

  // R5
  no_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((isSubFam(prevMode) && isRingFam(curMode)) || (isRingFam(prevMode) && isSubFam(curMode))));

  // R7
  lowpwr_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MD_SUBLP) |-> div8);

  // R7
  lowpwr_main_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MD_SUBLP && !busy) |-> !oscEn[SRC_MAIN]);

  // R8
  src_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcOf(curMode) != srcOf(prevMode)) |-> prevRdy[srcOf(curMode)]);

  // R9
  change_after_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != prevMode) |-> prevBusy);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevErr && !prevErrRd) |-> errFlag);

  // R4
  slow_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    slowAck |-> (prevMode != MD_PLL && !prevBusy));

endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .curMode (curMode),
  .oscRdy  (oscRdy),
  .oscEn   (oscEn),
  .div8    (div8),
  .busy    (busy),
  .errFlag (errFlag),
  .errRd   (errRd),
  .slowAck (slowAck)
);

// File: tb/clk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clk_mode_ctrl_bench;
  localparam int TO_W = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, slowReq = 0, div8Wr = 0, div8Val = 0, periphRingSel = 0, errRd = 0;
  logic [2:0] reqMode = 0;
  logic [1:0] reqDivCode = 0, reqMulCode = 0;
  logic [TO_W-1:0] timeoutCfg = 6'd5;
  logic [3:0] oscRdy = 4'hF;
  logic [2:0] curMode, mainDivLog2;
  logic [1:0] cpuSrc, pllMulCode;
  logic [3:0] oscEn;
  logic periphRing, div8, busy, errFlag, slowAck;

  always #2 clk = ~clk;

  clk_mode_ctrl #(.TO_W(TO_W)) u_clk_mode_ctrl (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int mMode = 2, mDiv = 0, mMul = 0, mLock = 1, mErr = 0, mRing = 0;

  function automatic bit okMove(int c, int t, int d8);
    if (t == 7) return 0;
    if (t == c) return 1;
    case (t)
      0: return !(c == 4 || c == 5 || c == 6);
      1: return c == 0;
      2: return (c == 1) ? 0 : ((c == 5 || c == 6) ? d8 != 0 : 1);
      3: return !(c == 1 || c == 5 || c == 6);
      4: return c == 3;
      5: return !(c == 1 || c == 3 || c == 4);
      default: return c == 5;
    endcase
  endfunction

  function automatic int expSrc(int m);
    case (m)
      1: return 2;
      3, 4: return 1;
      5, 6: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int expDiv(int m, int d, int l);
    if (m == 2) return (l != 0) ? 3 : d + 1;
    return 0;
  endfunction

  function automatic int expEn(int m, int rs);
    int e;
    e = 0;
    if (m <= 3) e |= 1;
    if (m == 3 || m == 4) e |= 2;
    if (m == 1) e |= 4;
    if (m == 5 || m == 6 || ((m == 3 || m == 4) && rs != 0)) e |= 8;
    return e;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag);
    chk({tag, " mode"}, curMode, mMode);
    chk({tag, " src"}, cpuSrc, expSrc(mMode));
    chk({tag, " div"}, mainDivLog2, expDiv(mMode, mDiv, mLock));
    chk({tag, " mul"}, pllMulCode, mMul);
    chk({tag, " lock"}, div8, mLock);
    chk({tag, " err"}, errFlag, mErr);
    chk({tag, " busy"}, busy, 0);
    chk({tag, " oscEn R12"}, oscEn, expEn(mMode, mRing));
    chk({tag, " periph R12"}, periphRing, (expEn(mMode, mRing) >> 3) & 1);
  endtask

  // request with every source ready: completes in two cycles
  task automatic sendReq(input int m, input int d, input int mul);
    reqValid = 1; reqMode = m[2:0]; reqDivCode = d[1:0]; reqMulCode = mul[1:0];
    @(negedge clk);
    reqValid = 0;
    @(negedge clk);
    if (okMove(mMode, m, mLock)) begin
      mMode = m; mDiv = d; mMul = mul;
      if (m == 4) mLock = 1;
    end else mErr = 1;
  endtask

  task automatic lockWr(input int v);
    div8Wr = 1; div8Val = v[0];
    @(negedge clk);
    div8Wr = 0;
    if (mMode != 4) mLock = v;
  endtask

  task automatic readErr();
    errRd = 1;
    @(negedge clk);
    errRd = 0;
    mErr = 0;
  endtask

  task automatic slowPulse(input string tag);
    slowReq = 1;
    @(negedge clk);
    slowReq = 0;
    if (mMode == 1) mErr = 1;
    chk({tag, " ack"}, slowAck, (mMode != 1) ? 1 : 0);
    chk({tag, " err"}, errFlag, mErr);
    @(negedge clk);
    chk({tag, " ack pulse end"}, slowAck, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1;
    chkState("R1 reset");

    sendReq(0, 0, 0);           chkState("R2 full-speed");
    lockWr(0);                  chk("R2 lock cleared", div8, 0);
    sendReq(2, 3, 0);           chkState("R2 medium /16");
    chk("R2 medium div", mainDivLog2, 4);
    sendReq(1, 0, 3);           chkState("R3 pll from medium rejected");
    readErr();
    sendReq(0, 1, 0);           chkState("R2 back to full-speed");
    sendReq(1, 0, 3);           chkState("R3 pll entry");
    chk("R3 pll mul", pllMulCode, 3);
    slowPulse("R4 wait in pll");
    readErr();
    sendReq(2, 0, 0);           chkState("R3 pll to medium rejected");
    chk("R11 mode kept", curMode, 1);
    readErr();
    sendReq(0, 0, 1);           chkState("R3 pll exit");
    slowPulse("R4 wait in full-speed");

    // R8 / R9: sub not ready, extra request while busy
    oscRdy = 4'b1101;
    reqValid = 1; reqMode = 3; reqDivCode = 0; reqMulCode = 1;
    @(negedge clk);
    reqMode = 5;                // arrives while busy: must be ignored
    chk("R8 busy", busy, 1);
    chk("R8 target osc enabled", oscEn, 4'b0011);
    @(negedge clk);
    reqValid = 0;
    slowReq = 1;
    @(negedge clk);
    slowReq = 0;
    chk("R9 no ack while busy", slowAck, 0);
    chk("R8 still waiting", curMode, 0);
    oscRdy = 4'hF;
    @(negedge clk);
    @(negedge clk);
    mMode = 3; mDiv = 0; mMul = 1;
    chkState("R9 ignored request");

    periphRingSel = 1; mRing = 1;
    @(negedge clk);
    chkState("R12 ring periph in sub mode");
    sendReq(5, 0, 1);           chkState("R5 sub to ring rejected");
    readErr();
    sendReq(4, 0, 1);           chkState("R7 enter low-power");
    chk("R7 lock forced", div8, 1);
    chk("R7 main off", oscEn[0], 0);
    lockWr(0);                  chk("R7 lock write ignored", div8, 1);
    sendReq(0, 0, 1);           chkState("R7 full-speed rejected");
    readErr();
    sendReq(5, 0, 1);           chkState("R5 low-power to ring rejected");
    readErr();
    sendReq(2, 1, 1);           chkState("R7 low-power to medium /8");
    chk("R7 medium div8", mainDivLog2, 3);
    periphRingSel = 0; mRing = 0;

    sendReq(5, 0, 0);           chkState("R8 medium to ring");
    sendReq(3, 0, 0);           chkState("R5 ring to sub rejected");
    readErr();
    lockWr(0);
    sendReq(2, 0, 0);           chkState("R6 ring to medium without lock rejected");
    readErr();
    sendReq(0, 0, 0);           chkState("R6 ring to full-speed rejected");
    readErr();
    lockWr(1);
    sendReq(2, 2, 0);           chkState("R6 ring to medium with lock");
    chk("R6 medium /8", mainDivLog2, 3);

    // R10 timeout
    oscRdy = 4'b1101;
    reqValid = 1; reqMode = 3;
    @(negedge clk);
    reqValid = 0;
    repeat (4) @(negedge clk);
    chk("R10 still waiting", busy, 1);
    repeat (4) @(negedge clk);
    mErr = 1;
    chkState("R10 abandoned");
    repeat (3) @(negedge clk);
    chk("R11 sticky", errFlag, 1);
    readErr();
    chk("R11 cleared", errFlag, 0);
    oscRdy = 4'hF;

    // random phase
    for (int i = 0; i < 800; i++) begin
      int op;
      op = $urandom % 6;
      if (op < 4)       sendReq($urandom % 8, $urandom % 4, $urandom % 4);
      else if (op == 4) lockWr($urandom % 2);
      else begin
        mRing = $urandom % 2; periphRingSel = mRing[0];
        @(negedge clk);
      end
      chkState("R2 R3 R5 R6 R7 random");
      if (mErr != 0) readErr();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule